// File: doc/BRIEF.md
# Power mode and heater controller

This block decides whether a pluggable test module runs in low-power or high-power mode and drives its heater elements. It holds the global control byte (a force-low bit, a low-power request bit and a self-clearing software reset bit) and combines it with the host's low-power pin. It reports the outcome as a 3-bit state code. In high-power mode each of the heater outputs is a pulse-width-modulated pin whose duty follows its own 8-bit duty value. In low-power mode every heater is held off.

An over-temperature guard compares the integer part of a signed, fixed-point temperature word against a programmable cut-off. Once the cut-off is reached, all heaters stop. They restart, with their stored duties untouched, only after the temperature has dropped five degrees below the cut-off. Writing the software reset bit produces a module reset pulse and restores the control byte to its power-on value. Sensor acquisition and nonvolatile storage are handled elsewhere.

Top module: `pwr_heat_ctrl`

## Requirements
- R1: The mode is low power when control bit 4 (force-low) is 1, or when control bit 6 (low-power request) and the low-power pin are both 1; every other combination is high power, and the mode follows its inputs two clock edges after a control write and one edge after a pin change.
- R2: The state code reads 3'b001 in low-power mode and 3'b011 in high-power mode, and no other value.
- R3: After reset the control byte reads 8'h40 (low-power request 1, force-low 0), the state code is low power with the pin high, the reset pulse is low and all heater outputs are low.
- R4: A write stores the control byte as given, except that bit 3 always reads back 0.
- R5: In high-power mode with no over-temperature, each heater output is high for exactly duty of every 256 consecutive cycles: duty 0 never high, duty 255 high for 255 cycles.
- R6: In low-power mode all heater outputs stay low; on return to high power each heater resumes its unchanged duty.
- R7: The heaters are forced off once the signed integer part of the temperature (upper byte of the 16-bit word, 1/256 degree units) is greater than or equal to the effective cut-off.
- R8: Once tripped, the heaters stay off until the temperature integer part is less than or equal to the effective cut-off minus 5, including when that threshold is negative; then the stored duties resume.
- R9: A cut-off value above 100 is limited to 100.
- R10: A control write with bit 3 set drives the reset pulse high for RST_CYCLES (default 4) consecutive cycles and returns the control byte to 8'h40.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte write value |
| lp_pin | input | 1 | Host low-power request pin, active high |
| cutoff | input | 8 | Cut-off temperature, whole degrees, unsigned |
| temp_in | input | 16 | Measured temperature, signed, 1/256 degree units |
| duty_flat | input | N_HEAT*8 | Heater duty values, channel 0 in the low byte |
| ctl_q | output | 8 | Control byte read-back |
| state_code | output | 3 | Module state code |
| mod_rst | output | 1 | Module reset pulse from software reset |
| pwm_out | output | N_HEAT | Heater PWM outputs |

## Verification
The bench builds the block with its default parameters: four heaters, 8-bit duties and a 16-bit temperature word. At these sizes one full PWM period is only 256 cycles, so every duty value from 0 to 255 is swept on all four channels with distinct patterns, and the high time is counted over a whole period. The force-low, request and pin inputs are small enough to walk the full eight-row truth table. The temperature is stepped across both hysteresis edges, at cut-offs of 100, above 100 (clamped), and small enough that the release point becomes negative.

// File: rtl/pwr_heat_pkg.sv
package pwr_heat_pkg;
  typedef enum logic [2:0] {
    ST_LOWPWR = 3'b001,
    ST_READY  = 3'b011
  } mod_state_e;

  localparam int CTL_SWRST_BIT  = 3;
  localparam int CTL_FORCE_BIT  = 4;
  localparam int CTL_LOWREQ_BIT = 6;
  localparam logic [7:0] CTL_DEFAULT = 8'h40;
endpackage

// File: rtl/pwr_mode_dec.sv
module pwr_mode_dec
  import pwr_heat_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       lp_pin,
  output logic [7:0] ctl_q,
  output logic       lp_mode,
  output logic [2:0] state_code,
  output logic       mod_rst
);
  localparam int RCNT_W = $clog2(RST_CYCLES + 1);

  logic [7:0]        ctl_r;
  logic              lp_r;
  logic [RCNT_W-1:0] rcnt;
  logic              swrst_req;

  assign swrst_req = wr_en && wr_data[CTL_SWRST_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_r <= CTL_DEFAULT;
      rcnt  <= '0;
    end else begin
      if (swrst_req) begin
        ctl_r <= CTL_DEFAULT;
        rcnt  <= RCNT_W'(RST_CYCLES);
      end else begin
        if (wr_en) begin
          ctl_r <= wr_data & ~(8'h01 << CTL_SWRST_BIT);
        end
        if (rcnt != '0) rcnt <= rcnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lp_r <= 1'b1;
    else     lp_r <= ctl_r[CTL_FORCE_BIT] | (ctl_r[CTL_LOWREQ_BIT] & lp_pin);
  end

  assign ctl_q      = ctl_r;
  assign lp_mode    = lp_r;
  assign mod_rst    = (rcnt != '0);
  assign state_code = lp_r ? ST_LOWPWR : ST_READY;

  // R1: force-low always yields low power on the next edge
  a_r1_force_lp: assert property (@(posedge clk) disable iff (rst)
    ctl_r[CTL_FORCE_BIT] |=> lp_r);
  // R2: only the two legal codes appear
  a_r2_code_legal: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'b001) || (state_code == 3'b011));
  // R4: software reset bit never reads back as 1
  a_r4_swrst_reads0: assert property (@(posedge clk) disable iff (rst)
    !ctl_q[CTL_SWRST_BIT]);
  // R10: a reset pulse only starts after a write with bit 3 set
  a_r10_pulse_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(mod_rst) |-> $past(wr_en && wr_data[CTL_SWRST_BIT]));
endmodule

// File: rtl/heat_cutoff.sv
module heat_cutoff #(
  parameter int TEMP_W  = 16,
  parameter int FRAC_W  = 8,
  parameter int CUT_W   = 8,
  parameter int CUT_MAX = 100,
  parameter int HYST    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CUT_W-1:0]  cutoff,
  input  logic [TEMP_W-1:0] temp_in,
  output logic              tripped
);
  localparam int INT_W = TEMP_W - FRAC_W;
  localparam int CMP_W = ((INT_W > CUT_W) ? INT_W : CUT_W) + 2;

  logic        [CUT_W-1:0] lim;
  logic signed [INT_W-1:0] t_int;
  logic signed [CMP_W-1:0] t_ext, lim_ext, rel_ext;
  logic                    trip_r;

  assign lim     = (cutoff > CUT_W'(CUT_MAX)) ? CUT_W'(CUT_MAX) : cutoff;
  assign t_int   = temp_in[TEMP_W-1:FRAC_W];
  assign t_ext   = CMP_W'(t_int);
  assign lim_ext = CMP_W'(lim);
  assign rel_ext = lim_ext - CMP_W'(HYST);

  always_ff @(posedge clk) begin
    if (rst) begin
      trip_r <= 1'b0;
    end else if (!trip_r) begin
      if (t_ext >= lim_ext) trip_r <= 1'b1;
    end else begin
      if (t_ext <= rel_ext) trip_r <= 1'b0;
    end
  end

  assign tripped = trip_r;

  // R7: a trip only follows a temperature at or above the limit
  a_r7_trip_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(trip_r) |-> $past(t_ext >= lim_ext));
  // R8: a release only follows a temperature at or below limit minus hysteresis
  a_r8_release_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(trip_r) |-> $past(t_ext <= rel_ext));
  // R9: the effective limit never exceeds the ceiling
  a_r9_clamp: assert property (@(posedge clk) disable iff (rst)
    (cutoff > CUT_W'(CUT_MAX)) |-> (lim == CUT_W'(CUT_MAX)));
endmodule

// File: rtl/heat_pwm.sv
module heat_pwm #(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W-1:0] phase,
  input  logic [DUTY_W-1:0] duty,
  input  logic              en,
  output logic              pwm
);
  logic pwm_r;

  always_ff @(posedge clk) begin
    if (rst) pwm_r <= 1'b0;
    else     pwm_r <= en && (phase < duty);
  end

  assign pwm = pwm_r;

  // R5: duty zero never drives the heater
  a_r5_duty0_off: assert property (@(posedge clk) disable iff (rst)
    (duty == '0) |=> !pwm_r);
endmodule

// File: rtl/pwr_heat_ctrl.sv
module pwr_heat_ctrl #(
  parameter int N_HEAT     = 4,
  parameter int DUTY_W     = 8,
  parameter int TEMP_W     = 16,
  parameter int FRAC_W     = 8,
  parameter int CUT_W      = 8,
  parameter int CUT_MAX    = 100,
  parameter int HYST       = 5,
  parameter int RST_CYCLES = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [7:0]               wr_data,
  input  logic                     lp_pin,
  input  logic [CUT_W-1:0]         cutoff,
  input  logic [TEMP_W-1:0]        temp_in,
  input  logic [N_HEAT*DUTY_W-1:0] duty_flat,
  output logic [7:0]               ctl_q,
  output logic [2:0]               state_code,
  output logic                     mod_rst,
  output logic [N_HEAT-1:0]        pwm_out
);
  logic              lp_mode;
  logic              tripped;
  logic              heat_en;
  logic [DUTY_W-1:0] phase;

  pwr_mode_dec #(.RST_CYCLES(RST_CYCLES)) mode_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .lp_pin(lp_pin),
    .ctl_q(ctl_q), .lp_mode(lp_mode), .state_code(state_code), .mod_rst(mod_rst)
  );

  heat_cutoff #(
    .TEMP_W(TEMP_W), .FRAC_W(FRAC_W), .CUT_W(CUT_W),
    .CUT_MAX(CUT_MAX), .HYST(HYST)
  ) cut_i (
    .clk(clk), .rst(rst), .cutoff(cutoff), .temp_in(temp_in), .tripped(tripped)
  );

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase + 1'b1;
  end

  assign heat_en = !lp_mode && !tripped;

  for (genvar g = 0; g < N_HEAT; g++) begin : g_heat
    heat_pwm #(.DUTY_W(DUTY_W)) pwm_i (
      .clk(clk), .rst(rst), .phase(phase),
      .duty(duty_flat[g*DUTY_W +: DUTY_W]), .en(heat_en), .pwm(pwm_out[g])
    );
  end

  // R6: low-power mode silences every heater on the next edge
  a_r6_lp_off: assert property (@(posedge clk) disable iff (rst)
    lp_mode |=> (pwm_out == '0));
  // R7: an active over-temperature trip silences every heater
  a_r7_trip_off: assert property (@(posedge clk) disable iff (rst)
    tripped |=> (pwm_out == '0));
endmodule

// File: tb/pwr_heat_ctrl_tb_top.sv
module pwr_heat_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NH = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_data = '0;
  logic          lp_pin = 1'b1;
  logic [7:0]    cutoff = 8'd100;
  logic [15:0]   temp_in = 16'h1900;
  logic [NH*8-1:0] duty_flat = '0;
  logic [7:0]    ctl_q;
  logic [2:0]    state_code;
  logic          mod_rst;
  logic [NH-1:0] pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int hc [NH];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_heat_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .lp_pin(lp_pin),
    .cutoff(cutoff), .temp_in(temp_in), .duty_flat(duty_flat),
    .ctl_q(ctl_q), .state_code(state_code), .mod_rst(mod_rst), .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_duty(input int d0, input int d1, input int d2, input int d3);
    duty_flat = {8'(d3), 8'(d2), 8'(d1), 8'(d0)};
  endtask

  task automatic measure();
    repeat (3) @(negedge clk);
    for (int i = 0; i < NH; i++) hc[i] = 0;
    for (int c = 0; c < 256; c++) begin
      for (int i = 0; i < NH; i++) hc[i] += int'(pwm_out[i]);
      @(negedge clk);
    end
  endtask

  task automatic chk_heat(input string req, input bit on, input int d0,
                          input int d1, input int d2, input int d3);
    measure();
    chk(req, hc[0], on ? d0 : 0);
    chk(req, hc[1], on ? d1 : 0);
    chk(req, hc[2], on ? d2 : 0);
    chk(req, hc[3], on ? d3 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int mc;
    set_duty(10, 20, 30, 40);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R3 reset state
    chk("R3 ctl", int'(ctl_q), 8'h40);
    chk("R3 state", int'(state_code), 3'b001);
    chk("R3 mod_rst", int'(mod_rst), 0);
    chk("R3 pwm", int'(pwm_out), 0);
    chk_heat("R3 heaters", 1'b0, 10, 20, 30, 40);

    // R5 exhaustive duty sweep in high-power mode
    lp_pin = 1'b0;
    wr_ctl(8'h00);
    for (int k = 0; k < 256; k++) begin
      set_duty(k, 255 - k, (k * 7 + 3) % 256, (k + 128) % 256);
      chk_heat("R5 duty", 1'b1, k, 255 - k, (k * 7 + 3) % 256, (k + 128) % 256);
    end

    // R1 R2 R6 full truth table
    set_duty(10, 20, 30, 40);
    for (int v = 0; v < 8; v++) begin
      bit f, l, p, exp_lp;
      f = v[2]; l = v[1]; p = v[0];
      exp_lp = f | (l & p);
      lp_pin = p;
      wr_ctl({1'b0, l, 1'b0, f, 4'b0000});
      @(negedge clk);
      chk("R1 R2 state", int'(state_code), exp_lp ? 3'b001 : 3'b011);
      chk_heat("R6 heaters", !exp_lp, 10, 20, 30, 40);
    end

    // R4 readback
    wr_ctl(8'hF7);
    chk("R4 readback", int'(ctl_q), 8'hF7);
    wr_ctl(8'h00);
    chk("R4 readback", int'(ctl_q), 8'h00);

    // R10 software reset pulse
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = 8'h18;
    @(negedge clk);
    wr_en = 1'b0;
    mc = 0;
    for (int c = 0; c < 10; c++) begin
      mc += int'(mod_rst);
      @(negedge clk);
    end
    chk("R10 pulse len", mc, 4);
    chk("R10 ctl default", int'(ctl_q), 8'h40);
    chk("R4 bit3 reads0", int'(ctl_q[3]), 0);

    // R7 R8 cut-off with hysteresis at 100
    lp_pin = 1'b0;
    wr_ctl(8'h00);
    cutoff = 8'd100;
    temp_in = 16'h63FF; chk_heat("R7 below", 1'b1, 10, 20, 30, 40);
    temp_in = 16'h6400; chk_heat("R7 trip", 1'b0, 10, 20, 30, 40);
    temp_in = 16'h6100; chk_heat("R8 hold", 1'b0, 10, 20, 30, 40);
    temp_in = 16'h6000; chk_heat("R8 hold", 1'b0, 10, 20, 30, 40);
    temp_in = 16'h5F00; chk_heat("R8 release", 1'b1, 10, 20, 30, 40);
    temp_in = 16'h6100; chk_heat("R8 no retrip", 1'b1, 10, 20, 30, 40);

    // R9 clamp of cut-off above 100
    cutoff = 8'd200;
    temp_in = 16'h6400; chk_heat("R9 clamp trip", 1'b0, 10, 20, 30, 40);
    temp_in = 16'h5F00; chk_heat("R9 clamp release", 1'b1, 10, 20, 30, 40);

    // R8 negative release threshold
    cutoff = 8'd3;
    temp_in = 16'h0200; chk_heat("R7 small below", 1'b1, 10, 20, 30, 40);
    temp_in = 16'h0300; chk_heat("R7 small trip", 1'b0, 10, 20, 30, 40);
    temp_in = 16'hFF00; chk_heat("R8 neg hold", 1'b0, 10, 20, 30, 40);
    temp_in = 16'hFE00; chk_heat("R8 neg release", 1'b1, 10, 20, 30, 40);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule